// File: doc/BRIEF.md
# Load data width conversion unit

This block formats one 64-bit raw memory read into the value that is written into a register element. The caller states the width the load was performed at, whether the byte-reversed form of the load was used, whether the core is in little-endian mode, whether saturation is wanted (and of which kind), and the element widths that override the source and destination sides. The block returns the converted element, right-aligned in a 64-bit word with every bit above the destination element width cleared.

The conversion always runs in one fixed order. First the raw word is cut to the operation width. Next, a byte swap inside that width is applied when the byte-reversed flag equals the little-endian flag. The result is then resized to the source override width. Finally it is resized, or saturated, to the destination override width. The stage is registered: a request presented with `in_valid` high appears on the outputs one clock later. While `in_valid` is low the outputs keep their last value.

Width codes are shared by the operation, source and destination fields: 2'b00 = 8 bits, 2'b01 = 16 bits, 2'b10 = 32 bits, 2'b11 = 64 bits.

Top module: `ldfmt_unit`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `out_valid` is high after that edge and `out_data` holds the conversion of the inputs sampled at that edge. When `in_valid` is low at an edge, `out_valid` is low after it and `out_data` keeps its previous value.
- R2: While `rst_n` is low, `out_valid` and `out_data` are zero.
- R3: Only the low bits of `raw_data` covered by `op_width` (codes 00/01/10/11 = 8/16/32/64 bits) take part in the result. Higher bits have no effect.
- R4: The bytes are swapped when `brev_op` equals `little_endian` (the XNOR of the two is 1). When the two differ, the byte order is left as it is.
- R5: A swap reverses byte order only inside the operation width, so that byte k goes to byte (N-1-k) for an N-byte operation.
- R6: With `sat_en` = 0, the value is zero-extended or truncated to `src_width` and then zero-extended or truncated to `dst_width`.
- R7: With `sat_en` = 1, the value is sign-extended from its operation-width top bit, or truncated, to `src_width`. It is then treated as a two's-complement number of that width.
- R8: With `sat_en` = 1 and `sat_signed` = 1, the result is clamped to the signed range of `dst_width`, from -2^(d-1) to 2^(d-1)-1, and is given in d-bit two's complement.
- R9: With `sat_en` = 1 and `sat_signed` = 0, a negative source value gives 0, and a value above 2^d-1 gives all ones in d bits.
- R10: With `sat_en` = 1 and `dst_width` not smaller than `src_width`, no clamping happens apart from R9's negative-to-zero rule. A signed result is the source value sign-extended to `dst_width`.
- R11: `out_data` bits at and above the destination width are zero.
- R12: The byte swap is applied before the source and destination resizing. After a swap, truncation keeps the low bytes of the swapped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe, also the register clock enable |
| raw_data | input | 64 | Raw memory read, right-aligned |
| op_width | input | 2 | Operation width code |
| brev_op | input | 1 | Byte-reversed form of the load |
| little_endian | input | 1 | Core little-endian mode |
| sat_en | input | 1 | Saturating conversion enable |
| sat_signed | input | 1 | Saturation kind: 0 unsigned, 1 signed |
| src_width | input | 2 | Source element width override code |
| dst_width | input | 2 | Destination element width override code |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | Converted element, zero above destination width |

## Verification
The datapath holds no state beyond the output register, so a wrong swap selection, extension mode or clamp bound shows up in the first result after the offending request, one clock after it is presented. A wrong enable or reset on the output register shows up as a changed `out_data` or `out_valid` in the idle cycle right after a request. The bench therefore compares every registered result against an independent model, both on random mixes of all width codes and flags and on directed values placed exactly at the clamp limits and the sign boundaries.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;
  localparam int DW      = 64;
  localparam int CODE_W  = 2;
  localparam int NCODES  = 1 << CODE_W;

  typedef enum logic [CODE_W-1:0] {
    W8  = 2'b00,
    W16 = 2'b01,
    W32 = 2'b10,
    W64 = 2'b11
  } wcode_e;

  // number of bits selected by a width code
  function automatic logic [6:0] code_bits(input logic [CODE_W-1:0] c);
    return 7'd8 << c;
  endfunction

  // low-bit mask for a width code
  function automatic logic [DW-1:0] code_mask(input logic [CODE_W-1:0] c);
    logic [DW-1:0] m;
    m = '1;
    if (c != W64) m = (64'd1 << code_bits(c)) - 64'd1;
    return m;
  endfunction
endpackage

// File: rtl/ldfmt_swap.sv
module ldfmt_swap
  import ldfmt_pkg::*;
#(
  parameter int DATA_W = DW
) (
  input  logic [DATA_W-1:0] raw,
  input  logic [CODE_W-1:0] op_code,
  input  logic              do_swap,
  output logic [DATA_W-1:0] op_val
);
  localparam int NB = DATA_W / 8;

  logic [DATA_W-1:0] cut;
  logic [DATA_W-1:0] rev [NCODES];

  assign cut = raw & code_mask(op_code);

  // one reversal network per operation width
  for (genvar g = 0; g < NCODES; g++) begin : g_width
    localparam int GB = 1 << g;
    for (genvar k = 0; k < NB; k++) begin : g_byte
      if (k < GB) begin : g_in
        assign rev[g][8*k +: 8] = cut[8*(GB-1-k) +: 8];
      end else begin : g_out
        assign rev[g][8*k +: 8] = 8'h00;
      end
    end
  end

  always_comb begin
    op_val = cut;
    if (do_swap) op_val = rev[op_code];
  end
endmodule

// File: rtl/ldfmt_src_adj.sv
module ldfmt_src_adj
  import ldfmt_pkg::*;
#(
  parameter int DATA_W = DW
) (
  input  logic [DATA_W-1:0] op_val,
  input  logic [CODE_W-1:0] op_code,
  input  logic [CODE_W-1:0] src_code,
  input  logic              sat_en,
  output logic [DATA_W-1:0] src_val
);
  logic [6:0]               sh;
  logic signed [DATA_W-1:0] sext;
  logic [DATA_W-1:0]        wide;

  always_comb begin
    sh   = 7'(DATA_W) - code_bits(op_code);
    sext = $signed(op_val << sh) >>> sh;
    wide = sat_en ? DATA_W'(sext) : op_val;
    src_val = wide & code_mask(src_code);
  end
endmodule

// File: rtl/ldfmt_dst_adj.sv
module ldfmt_dst_adj
  import ldfmt_pkg::*;
#(
  parameter int DATA_W = DW
) (
  input  logic [DATA_W-1:0] src_val,
  input  logic [CODE_W-1:0] src_code,
  input  logic [CODE_W-1:0] dst_code,
  input  logic              sat_en,
  input  logic              sat_signed,
  output logic [DATA_W-1:0] dst_val
);
  logic [6:0]               sh;
  logic [6:0]               dbits;
  logic [DATA_W-1:0]        dmask;
  logic signed [DATA_W-1:0] sval;
  logic signed [DATA_W-1:0] smax;
  logic signed [DATA_W-1:0] smin;
  logic [DATA_W-1:0]        clamped;

  always_comb begin
    sh    = 7'(DATA_W) - code_bits(src_code);
    sval  = $signed(src_val << sh) >>> sh;
    dbits = code_bits(dst_code);
    dmask = code_mask(dst_code);
    smax  = $signed((64'd1 << (dbits - 7'd1)) - 64'd1);
    smin  = ~smax;
    clamped = src_val;
    if (sat_signed) begin
      if (sval > smax)      clamped = smax;
      else if (sval < smin) clamped = smin;
      else                  clamped = sval;
    end else begin
      if (sval[DATA_W-1])               clamped = '0;
      else if ((sval & ~dmask) != '0)   clamped = dmask;
      else                              clamped = sval;
    end
    dst_val = (sat_en ? clamped : src_val) & dmask;
  end
endmodule

// File: rtl/ldfmt_unit.sv
module ldfmt_unit
  import ldfmt_pkg::*;
#(
  parameter int DATA_W = DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] raw_data,
  input  logic [1:0]        op_width,
  input  logic              brev_op,
  input  logic              little_endian,
  input  logic              sat_en,
  input  logic              sat_signed,
  input  logic [1:0]        src_width,
  input  logic [1:0]        dst_width,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic              swap_en;
  logic [DATA_W-1:0] op_val;
  logic [DATA_W-1:0] src_val;
  logic [DATA_W-1:0] dst_val;
  logic              valid_d, valid_q;
  logic [DATA_W-1:0] data_d,  data_q;

  assign swap_en = ~(brev_op ^ little_endian);

  ldfmt_swap #(.DATA_W(DATA_W)) u_swap (
    .raw     (raw_data),
    .op_code (op_width),
    .do_swap (swap_en),
    .op_val  (op_val)
  );

  ldfmt_src_adj #(.DATA_W(DATA_W)) u_src (
    .op_val   (op_val),
    .op_code  (op_width),
    .src_code (src_width),
    .sat_en   (sat_en),
    .src_val  (src_val)
  );

  ldfmt_dst_adj #(.DATA_W(DATA_W)) u_dst (
    .src_val    (src_val),
    .src_code   (src_width),
    .dst_code   (dst_width),
    .sat_en     (sat_en),
    .sat_signed (sat_signed),
    .dst_val    (dst_val)
  );

  // next state
  always_comb begin
    valid_d = in_valid;
    data_d  = data_q;
    if (in_valid) data_d = dst_val;
  end

  // state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_data)));

  // R11
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_data & ~code_mask($past(dst_width))) == '0));

  // R6
  plain_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sat_en && (brev_op != little_endian) &&
     op_width == W64 && src_width == W64 && dst_width == W64)
    |=> (out_data == $past(raw_data)));
endmodule

// File: tb/ldfmt_unit_tb.sv
module ldfmt_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] raw_data;
  logic [1:0]  op_width, src_width, dst_width;
  logic        brev_op, little_endian, sat_en, sat_signed;
  logic        out_valid;
  logic [63:0] out_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  ldfmt_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .raw_data(raw_data),
    .op_width(op_width), .brev_op(brev_op), .little_endian(little_endian),
    .sat_en(sat_en), .sat_signed(sat_signed), .src_width(src_width),
    .dst_width(dst_width), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [63:0] mk(input int bits);
    return (bits >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << bits) - 64'd1);
  endfunction

  function automatic logic [63:0] model(
    input logic [63:0] raw, input logic [1:0] oc, input logic br, input logic le,
    input logic se, input logic sg, input logic [1:0] sc, input logic [1:0] dc);
    int ob = 1 << oc;
    int sb = 8 << sc;
    int db = 8 << dc;
    logic [63:0] a = '0;
    logic [63:0] b = '0;
    longint s, hi, lo;
    for (int k = 0; k < ob; k++) a[8*k +: 8] = raw[8*k +: 8];
    if (br == le) begin
      for (int k = 0; k < ob; k++) b[8*k +: 8] = a[8*(ob-1-k) +: 8];
      a = b;
    end
    if (!se) return a & mk(sb) & mk(db);
    for (int i = 8*ob; i < 64; i++) a[i] = a[8*ob-1];
    a = a & mk(sb);
    for (int i = sb; i < 64; i++) a[i] = a[sb-1];
    s = longint'(a);
    if (sg) begin
      hi = (db == 64) ? 64'sh7FFF_FFFF_FFFF_FFFF : ((64'sd1 <<< (db-1)) - 64'sd1);
      lo = -hi - 64'sd1;
      if (s > hi) s = hi;
      else if (s < lo) s = lo;
    end else begin
      if (s < 0) s = 0;
      else if (db < 64 && s > longint'(mk(db))) s = longint'(mk(db));
    end
    return 64'(s) & mk(db);
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // called at a negedge: drive, wait one edge, compare at next negedge
  task automatic run(input string tag, input logic [63:0] raw, input logic [1:0] oc,
    input logic br, input logic le, input logic se, input logic sg,
    input logic [1:0] sc, input logic [1:0] dc, input logic [63:0] exp);
    in_valid = 1'b1; raw_data = raw; op_width = oc; brev_op = br;
    little_endian = le; sat_en = se; sat_signed = sg; src_width = sc; dst_width = dc;
    @(negedge clk);
    chk({tag, " valid"}, {63'd0, out_valid}, 64'd1);
    chk(tag, out_data, exp);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] r, e;
    logic [1:0]  oc, sc, dc;
    logic        br, le, se, sg;
    void'($urandom(32'd2024));
    rst_n = 1'b0; in_valid = 1'b0; raw_data = '0; op_width = 2'b11;
    brev_op = 1'b0; little_endian = 1'b1; sat_en = 1'b0; sat_signed = 1'b0;
    src_width = 2'b11; dst_width = 2'b11;
    repeat (3) @(negedge clk);
    chk("R2 reset valid", {63'd0, out_valid}, 64'd0);
    chk("R2 reset data", out_data, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run("R1 R6 identity", 64'h0123_4567_89AB_CDEF, 2'b11, 0, 1, 0, 0, 2'b11, 2'b11, 64'h0123_4567_89AB_CDEF);
    run("R4 R5 swap16", 64'h0123_4567_89AB_CDEF, 2'b01, 0, 0, 0, 0, 2'b01, 2'b01, 64'h0000_0000_0000_EFCD);
    run("R4 R5 swap32 both set", 64'h0123_4567_89AB_CDEF, 2'b10, 1, 1, 0, 0, 2'b10, 2'b10, 64'h0000_0000_EFCD_AB89);
    run("R4 no swap differ", 64'h0123_4567_89AB_CDEF, 2'b10, 1, 0, 0, 0, 2'b10, 2'b10, 64'h0000_0000_89AB_CDEF);
    run("R4 R5 swap64", 64'h0123_4567_89AB_CDEF, 2'b11, 0, 0, 0, 0, 2'b11, 2'b11, 64'hEFCD_AB89_6745_2301);
    run("R3 upper ignored", 64'hFFFF_FFFF_FFFF_FF5A, 2'b00, 0, 1, 0, 0, 2'b11, 2'b11, 64'h0000_0000_0000_005A);
    run("R6 truncate", 64'h0000_0000_1234_5678, 2'b10, 0, 1, 0, 0, 2'b01, 2'b00, 64'h0000_0000_0000_0078);
    run("R6 zero extend", 64'h0000_0000_0000_0080, 2'b00, 0, 1, 0, 0, 2'b11, 2'b11, 64'h0000_0000_0000_0080);
    run("R7 R10 sign extend", 64'h0000_0000_0000_0080, 2'b00, 0, 1, 1, 1, 2'b10, 2'b01, 64'h0000_0000_0000_FF80);
    run("R9 negative to zero", 64'h0000_0000_0000_0080, 2'b00, 0, 1, 1, 0, 2'b10, 2'b01, 64'h0);
    run("R8 clamp high", 64'h0000_0000_0001_2345, 2'b10, 0, 1, 1, 1, 2'b10, 2'b00, 64'h0000_0000_0000_007F);
    run("R8 clamp low", 64'h0000_0000_FFFE_0000, 2'b10, 0, 1, 1, 1, 2'b10, 2'b00, 64'h0000_0000_0000_0080);
    run("R9 clamp high", 64'h0000_0000_0001_2345, 2'b10, 0, 1, 1, 0, 2'b10, 2'b01, 64'h0000_0000_0000_FFFF);
    run("R8 in range", 64'h0000_0000_0000_FFF0, 2'b01, 0, 1, 1, 1, 2'b01, 2'b00, 64'h0000_0000_0000_00F0);
    run("R8 at max", 64'h0000_0000_0000_007F, 2'b01, 0, 1, 1, 1, 2'b01, 2'b00, 64'h0000_0000_0000_007F);
    run("R10 widen signed", 64'h0000_0000_0000_8001, 2'b01, 0, 1, 1, 1, 2'b01, 2'b11, 64'hFFFF_FFFF_FFFF_8001);
    run("R7 truncate sat", 64'h0000_0000_0001_FFFF, 2'b10, 0, 1, 1, 1, 2'b01, 2'b10, 64'h0000_0000_FFFF_FFFF);
    run("R12 swap then cut", 64'h0000_0000_1122_3344, 2'b10, 0, 0, 0, 0, 2'b00, 2'b00, 64'h0000_0000_0000_0011);
    run("R11 upper zero", 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 0, 1, 1, 1, 2'b11, 2'b01, 64'h0000_0000_0000_FFFF);

    // idle cycle: new inputs without in_valid must not reach the outputs
    in_valid = 1'b0; raw_data = 64'hDEAD_BEEF_DEAD_BEEF; op_width = 2'b11;
    sat_en = 1'b0; src_width = 2'b11; dst_width = 2'b11;
    @(negedge clk);
    chk("R1 idle valid", {63'd0, out_valid}, 64'd0);
    chk("R1 idle hold", out_data, 64'h0000_0000_0000_FFFF);

    for (int n = 0; n < 400; n++) begin
      r  = {$urandom, $urandom};
      oc = 2'($urandom); sc = 2'($urandom); dc = 2'($urandom);
      br = 1'($urandom); le = 1'($urandom); se = 1'($urandom); sg = 1'($urandom);
      if (n % 4 == 0) r = {$urandom, $urandom} & 64'hFFFF;
      e = model(r, oc, br, le, se, sg, sc, dc);
      run(se ? (sg ? "R8 rand" : "R9 rand") : "R6 rand", r, oc, br, le, se, sg, sc, dc, e);
      if (n % 7 == 0) begin
        raw_data = ~r;
        @(negedge clk);
        chk("R1 rand hold", out_data, e);
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule